// File: doc/BRIEF.md
# Stochastic Weight Cell with Momentum Smoothing

This block holds one synaptic weight of a bit-stream neural network and changes it during training. An incoming stream of weight-change bits, where the probability of a 1 encodes a signed change, first passes through a smoothing stage. That stage is a bounded up/down counter whose coded output stream is pulled toward the probability of its input, so it acts as a moving average, much like a momentum term. The smoothed stream then drives a second bounded counter, which integrates it: +1 for every 1 and -1 for every 0. A comparator against a fresh random word turns that count back into the outgoing weight bit stream.

Both counters are bounded and have a switchable length. The longer length gives finer weight resolution and slower learning, while the shorter one learns faster and more coarsely. When learning is disabled, both counters hold their values and the weight stream is still produced. The mid-scale count stands for a signed weight of zero, and reset loads it.

Top module: `stoch_weight_cell`

## Requirements
- R1: While `rst_n` is low, both counters load the mid-scale value of the selected length, 2^(L-1) for an L-bit length. With the default parameters the weight count after reset is 2048 when `len_short`=0 and 1024 when `len_short`=1.
- R2: Each coder drives 1 exactly when its random word, with the bits above the selected length forced to 0, is strictly less than its counter value. This output is combinational.
- R3: With `learn_en`=1, the weight count rises by 1 on a clock where the smoothed bit is 1 and falls by 1 where it is 0. Apart from a length clamp, it never moves by more than 1 per clock.
- R4: Both counters saturate: they hold at 0 and at 2^L-1 and never wrap. The weight maximum is 4095 in the long length and 2047 in the short length.
- R5: With `learn_en`=1, the smoothing counter increments when `upd_bit`=1 and its own coded bit is 0. It decrements when `upd_bit`=0 and its coded bit is 1. In every other case it holds.
- R6: With `learn_en`=0, both counters keep their values, and `wgt_bit` still follows R2.
- R7: `len_short`=1 selects W-SHORT_DROP bits and 0 selects W bits, for both counters. A count above the newly selected maximum is clamped to that maximum on the next clock, whether or not learning is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| learn_en | input | 1 | 1 = update counters, 0 = freeze |
| len_short | input | 1 | 1 = short counter/coder length |
| upd_bit | input | 1 | Incoming weight-change bit stream |
| mom_rnd | input | MOM_W | Random word for the smoothing coder |
| wgt_rnd | input | WGT_W | Random word for the weight coder |
| wgt_bit | output | 1 | Outgoing weight bit stream |
| wgt_count | output | WGT_W | Parallel weight counter value |

## Verification
The assertions check, on every cycle, the properties that hold regardless of stimulus. Each counter stays within its current maximum, moves by at most one step unless it is clamped, holds when it has no step request, and saturates at its maximum. The smoothing counter also holds whenever its input bit equals its own coded bit. Only the bench's scenarios can show the effects that need a chosen sequence of random words:
- the actual tracking direction of the smoothing counter, probed through the weight count;
- the masking of random words in the short length;
- the mid-scale reset values;
- the clamp on a length change;
- the frozen state surviving a learning pause.

// File: rtl/stoch_weight_pkg.sv
package stoch_weight_pkg;

   // mask of the low 'len' bits of a W-bit word
   function automatic logic [31:0] low_mask(input int unsigned len);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < 32; i++)
         if (i < int'(len)) m[i] = 1'b1;
      return m;
   endfunction

   // mid-scale value (signed zero) for a given limit mask
   function automatic logic [31:0] mid_of(input logic [31:0] mask);
      return (mask >> 1) + 32'd1;
   endfunction

endpackage

// File: rtl/sat_len_counter.sv
module sat_len_counter #(
   parameter int unsigned W          = 12,
   parameter int unsigned SHORT_DROP = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         short_sel,
   input  logic         inc,
   input  logic         dec,
   output logic [W-1:0] cnt,
   output logic [W-1:0] lim
);
   import stoch_weight_pkg::*;

   localparam int unsigned SHORT_W = W - SHORT_DROP;
   localparam logic [W-1:0] LIM_LONG  = W'(low_mask(W));
   localparam logic [W-1:0] LIM_SHORT = W'(low_mask(SHORT_W));

   if (W < 2 || W > 31) begin : g_bad_w
      $error("sat_len_counter: W must be in 2..31");
   end
   if (SHORT_DROP >= W - 1) begin : g_bad_drop
      $error("sat_len_counter: SHORT_DROP too large");
   end

   if (SHORT_DROP == 0) begin : g_fixed_len
      assign lim = LIM_LONG;
   end else begin : g_switch_len
      assign lim = short_sel ? LIM_SHORT : LIM_LONG;
   end

   logic [W-1:0] mid;
   logic [W-1:0] cnt_nx;
   assign mid = W'(mid_of(32'(lim)));

   always_comb begin
      cnt_nx = cnt;
      if (cnt > lim)
         cnt_nx = lim;
      else if (inc && !dec && cnt != lim)
         cnt_nx = cnt + W'(1);
      else if (dec && !inc && cnt != '0)
         cnt_nx = cnt - W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= mid;
      else        cnt <= cnt_nx;
   end

   // R4 / R7: count never above the current maximum
   a_r4_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(lim) |-> cnt <= lim);

   // R3 / R7: at most one step per clock unless clamped
   a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt <= lim) |=> ({1'b0, cnt} == {1'b0, $past(cnt)}
                     || {1'b0, cnt} == {1'b0, $past(cnt)} + (W+1)'(1)
                     || {1'b0, cnt} + (W+1)'(1) == {1'b0, $past(cnt)}
                     || cnt == lim));

   // R6: no request, no change
   a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !dec && cnt <= lim) |=> cnt == $past(cnt));

   // R4: saturate at maximum
   a_r4_top_sat: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !dec && cnt == lim) |=> cnt == $past(cnt));

   // R4: saturate at zero
   a_r4_bottom_sat: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc && cnt == '0) |=> cnt == '0);

endmodule

// File: rtl/stream_coder.sv
module stream_coder #(
   parameter int unsigned W = 12
) (
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] rnd,
   input  logic [W-1:0] mask,
   output logic         bit_o
);
   if (W < 1) begin : g_bad_w
      $error("stream_coder: W must be positive");
   end

   logic [W-1:0] rnd_m;
   assign rnd_m = rnd & mask;
   assign bit_o = (rnd_m < cnt);
endmodule

// File: rtl/stoch_weight_cell.sv
module stoch_weight_cell #(
   parameter int unsigned MOM_W      = 15,
   parameter int unsigned WGT_W      = 12,
   parameter int unsigned SHORT_DROP = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             learn_en,
   input  logic             len_short,
   input  logic             upd_bit,
   input  logic [MOM_W-1:0] mom_rnd,
   input  logic [WGT_W-1:0] wgt_rnd,
   output logic             wgt_bit,
   output logic [WGT_W-1:0] wgt_count
);
   if (MOM_W < WGT_W) begin : g_bad_order
      $error("stoch_weight_cell: momentum counter narrower than weight counter");
   end

   logic [MOM_W-1:0] mom_cnt, mom_lim;
   logic [WGT_W-1:0] wgt_lim;
   logic             mom_bit;
   logic             mom_inc, mom_dec, wgt_inc, wgt_dec;

   // smoothing stage: pull its coded bit toward the input probability
   assign mom_inc = learn_en &  upd_bit & ~mom_bit;
   assign mom_dec = learn_en & ~upd_bit &  mom_bit;

   sat_len_counter #(.W(MOM_W), .SHORT_DROP(SHORT_DROP)) u_mom_cnt (
      .clk(clk), .rst_n(rst_n), .short_sel(len_short),
      .inc(mom_inc), .dec(mom_dec), .cnt(mom_cnt), .lim(mom_lim));

   stream_coder #(.W(MOM_W)) u_mom_code (
      .cnt(mom_cnt), .rnd(mom_rnd), .mask(mom_lim), .bit_o(mom_bit));

   // integrating stage: +1 on a smoothed 1, -1 on a smoothed 0
   assign wgt_inc = learn_en &  mom_bit;
   assign wgt_dec = learn_en & ~mom_bit;

   sat_len_counter #(.W(WGT_W), .SHORT_DROP(SHORT_DROP)) u_wgt_cnt (
      .clk(clk), .rst_n(rst_n), .short_sel(len_short),
      .inc(wgt_inc), .dec(wgt_dec), .cnt(wgt_count), .lim(wgt_lim));

   stream_coder #(.W(WGT_W)) u_wgt_code (
      .cnt(wgt_count), .rnd(wgt_rnd), .mask(wgt_lim), .bit_o(wgt_bit));

   // R5: input agreeing with own coded bit leaves smoothing counter unchanged
   a_r5_adapt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (learn_en && upd_bit == mom_bit && mom_cnt <= mom_lim) |=> mom_cnt == $past(mom_cnt));

   // R6: frozen weight while learning is off
   a_r6_weight_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!learn_en && wgt_count <= wgt_lim) |=> wgt_count == $past(wgt_count));
endmodule

// File: tb/stoch_weight_cell_test.sv
`timescale 1ns/1ps
module stoch_weight_cell_test;
   localparam int MOM_W = 15;
   localparam int WGT_W = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic learn_en = 1'b0;
   logic len_short = 1'b0;
   logic upd_bit = 1'b0;
   logic [MOM_W-1:0] mom_rnd = '0;
   logic [WGT_W-1:0] wgt_rnd = '0;
   logic wgt_bit;
   logic [WGT_W-1:0] wgt_count;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   stoch_weight_cell #(.MOM_W(MOM_W), .WGT_W(WGT_W), .SHORT_DROP(1)) uut (
      .clk(clk), .rst_n(rst_n), .learn_en(learn_en), .len_short(len_short),
      .upd_bit(upd_bit), .mom_rnd(mom_rnd), .wgt_rnd(wgt_rnd),
      .wgt_bit(wgt_bit), .wgt_count(wgt_count));

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic do_reset(input logic short_len);
      rst_n = 1'b0; learn_en = 1'b0; upd_bit = 1'b0;
      len_short = short_len; mom_rnd = '0; wgt_rnd = '0;
      cyc(2);
      rst_n = 1'b1;
      cyc(1);
   endtask

   task automatic coder_bit(input int rnd, input int exp, input string req);
      wgt_rnd = WGT_W'(rnd);
      #1;
      chk(req, int'(wgt_bit), exp);
   endtask

   // R1, R2: reset state and coder threshold
   task automatic t_reset_long;
      do_reset(1'b0);
      chk("R1 long reset", int'(wgt_count), 2048);
      coder_bit(2047, 1, "R2 below count");
      coder_bit(2048, 0, "R2 equal count");
   endtask

   // R3, R5: integration and smoothing direction
   task automatic t_momentum;
      do_reset(1'b0);
      learn_en = 1'b1; upd_bit = 1'b1; mom_rnd = '0;
      cyc(10);
      chk("R3 up ten", int'(wgt_count), 2058);
      mom_rnd = 15'h7FFF;
      cyc(5);
      chk("R3 down five", int'(wgt_count), 2053);
      mom_rnd = 15'd16388; cyc(1);
      chk("R5 increment seen", int'(wgt_count), 2054);
      mom_rnd = 15'd16389; cyc(1);
      chk("R5 increment boundary", int'(wgt_count), 2053);
      upd_bit = 1'b0; mom_rnd = '0;
      cyc(3);
      chk("R3 up while smoothing falls", int'(wgt_count), 2056);
      upd_bit = 1'b1; mom_rnd = 15'd16386; cyc(1);
      chk("R5 decrement seen", int'(wgt_count), 2057);
      mom_rnd = 15'd16387; cyc(1);
      chk("R5 decrement boundary", int'(wgt_count), 2056);
   endtask

   // R6: freeze (continues from t_momentum state, smoothing count 16388)
   task automatic t_freeze;
      learn_en = 1'b0; upd_bit = 1'b1; mom_rnd = '0;
      cyc(5);
      chk("R6 weight frozen", int'(wgt_count), 2056);
      coder_bit(2055, 1, "R6 stream during freeze");
      coder_bit(2056, 0, "R6 stream during freeze");
      upd_bit = 1'b0; mom_rnd = '0;
      cyc(5);
      learn_en = 1'b1; upd_bit = 1'b1; mom_rnd = 15'd16387; cyc(1);
      chk("R6 smoothing frozen", int'(wgt_count), 2057);
   endtask

   // R4, R7: saturation and clamp
   task automatic t_saturate;
      do_reset(1'b0);
      learn_en = 1'b1; upd_bit = 1'b1; mom_rnd = '0;
      cyc(2100);
      chk("R4 top long", int'(wgt_count), 4095);
      coder_bit(4094, 1, "R2 top");
      coder_bit(4095, 0, "R2 top");
      learn_en = 1'b0; len_short = 1'b1;
      cyc(1);
      chk("R7 clamp to short max", int'(wgt_count), 2047);
      learn_en = 1'b1; upd_bit = 1'b0; mom_rnd = 15'h7FFF;
      cyc(2100);
      chk("R4 bottom", int'(wgt_count), 0);
      coder_bit(0, 0, "R2 zero count");
   endtask

   // R1, R2, R4, R7: short length
   task automatic t_short;
      do_reset(1'b1);
      chk("R1 short reset", int'(wgt_count), 1024);
      coder_bit(12'hBFF, 1, "R2 masked high bit");
      coder_bit(12'h400, 0, "R2 masked equal");
      learn_en = 1'b1; upd_bit = 1'b1; mom_rnd = '0;
      cyc(1100);
      chk("R4 R7 top short", int'(wgt_count), 2047);
   endtask

   initial begin
      t_reset_long();
      t_momentum();
      t_freeze();
      t_saturate();
      t_short();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule